// File: doc/BRIEF.md
# Fractional Sampling-Rate Tick Generator

This block turns a free-running reference clock into the oversampling tick that a UART transmitter and receiver use to time their bits. The reference first goes through a front prescaler (divide by 1 or by 4). A divider then splits the prescaled rate by a programmable amount that has a 16-bit integer part and a 4-bit fraction counted in sixteenths. The divider emits a one-cycle sample tick. A small group counter turns every 16 sample ticks, or every 8 in the reduced-oversampling mode, into a one-cycle bit tick.

A non-integer divisor N + F/16 works like this. Every sample period is either N or N+1 prescaled cycles long. A 4-bit phase accumulator adds F on each sample tick, and its carry lengthens the next period by one cycle. Over any 16 sample ticks the total is exactly 16N + F prescaled cycles, and no single period is off by more than one cycle. Configuration comes from plain register values: a high divisor byte, a low divisor byte, a fraction nibble, a prescaler select and an oversampling mode bit. A change in any of them restarts the divider cleanly.

Top module: `frac_baud_gen`

## Requirements
- R1: With prescaler select 0 (divide by 1), a fraction of 0 and integer divisor N = {high byte, low byte} ≥ 1, `samp_tick` is a one-cycle pulse that repeats every N clock cycles.
- R2: With fraction F (in sixteenths), every interval between consecutive sample ticks is N or N+1 prescaled cycles. Any 16 consecutive intervals add up to exactly 16N + F. Example: high 0x01, low 0x38, fraction 0x8 gives intervals of 312 or 313 that add up to 5000 over 16.
- R3: Divisors below 2 work. With low 0x01 and fraction 0xA, the intervals are 1 or 2 cycles and any 16 of them add up to 26.
- R4: With prescaler select 1, the divider advances only once every 4 clock cycles. For N = 3 and F = 0 the sample ticks come 12 cycles apart.
- R5: With `mode_8x` = 0, `bit_tick` pulses for one cycle, one clock cycle after every 16th sample tick counted from a restart. Consecutive bit ticks are therefore 16N + F cycles apart.
- R6: With `mode_8x` = 1, a bit tick follows every 8th sample tick. For N = 4 and F = 0 the bit period is 32 cycles. For N = 3 and F = 6, two consecutive bit periods add up to 54 cycles.
- R7: When the integer part N is 0, no sample tick and no bit tick is produced, whatever the fraction is.
- R8: Any change in the value of a divisor byte, the fraction, the prescaler select or the mode restarts the block. The counter, the phase accumulator and the group counter are cleared. With the divide-by-1 prescaler, the first sample tick appears N+2 clock cycles after the cycle in which the new value is first presented, and a tick that was due earlier is dropped. After a restart the accumulator starts at 0: for N = 3 and F = 14 the first two intervals are 3 and then 4.
- R9: While `rst` is high, and right after it, both outputs are low. The reset defaults are a divisor of zero, prescaler divide by 1 and 16X oversampling.
- R10: An integer divisor of 3750 (high 0x0E, low 0xA6, fraction 0) in 16X mode gives 60000 reference cycles per bit. That is 400 bit/s from a 24 MHz reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| div_hi | input | 8 | Upper byte of the integer divisor |
| div_lo | input | 8 | Lower byte of the integer divisor |
| div_frac | input | 4 | Fractional divisor in sixteenths |
| pre_sel | input | 1 | Prescaler select: 0 divides by 1, 1 divides by 4 |
| mode_8x | input | 1 | Oversampling: 0 gives 16 samples per bit, 1 gives 8 |
| samp_tick | output | 1 | One-cycle oversampling tick |
| bit_tick | output | 1 | One-cycle tick at the bit rate |

## Verification
Two things can land on the same clock edge: a sample tick that the running count has made due, and a configuration change that forces a restart. The bench runs a divisor of 5, waits for one tick, and then changes the divisor to 7 on the last cycle before the next tick would fire. It then checks that no tick appears in that slot and that the first tick comes exactly 7 + 2 cycles after the change, so the restart takes priority over the pending tick. A second case checks that a restart also clears the phase accumulator. It does this by comparing the first intervals after a fraction change with the values computed from a zeroed accumulator.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int BYTE_W = 8;
  localparam int DIV_W  = 2 * BYTE_W;

  typedef struct packed {
    logic [DIV_W-1:0] int_part;
    logic [3:0]       frac_part;
    logic             pre_sel;
    logic             mode_8x;
  } fbg_cfg_t;
endpackage

// File: rtl/fbg_prescaler.sv
module fbg_prescaler #(
  parameter int RATIO = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic reload,
  input  logic sel,
  output logic en
);
  localparam int CW = (RATIO > 2) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] cnt_q;
  logic          en_q;

  always_ff @(posedge clk) begin
    if (rst || reload) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      en_q  <= sel ? (cnt_q == LAST) : 1'b1;
    end
  end

  assign en = en_q;

  // R4: in divide-by-RATIO mode an enable is never followed by another at once
  a_r4_pre_gap: assert property (@(posedge clk) disable iff (rst)
    (sel && $stable(sel) && en_q) |=> !en_q);
endmodule

// File: rtl/fbg_divider.sv
module fbg_divider #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reload,
  input  logic              en,
  input  logic [INT_W-1:0]  n,
  input  logic [FRAC_W-1:0] f,
  output logic              tick
);
  logic [INT_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic              ext_q;
  logic              tick_q;

  logic [INT_W:0]    period;
  logic [INT_W:0]    cnt_next;
  logic [FRAC_W:0]   acc_sum;
  logic              hit;
  logic              active;

  always_comb begin
    period   = {1'b0, n} + {{INT_W{1'b0}}, ext_q};
    cnt_next = {1'b0, cnt_q} + 1'b1;
    hit      = (cnt_next == period);
    acc_sum  = {1'b0, acc_q} + {1'b0, f};
    active   = (n != '0);
  end

  always_ff @(posedge clk) begin
    if (rst || reload) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      ext_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (en && active) begin
        if (hit) begin
          cnt_q  <= '0;
          acc_q  <= acc_sum[FRAC_W-1:0];
          ext_q  <= acc_sum[FRAC_W];
          tick_q <= 1'b1;
        end else begin
          cnt_q <= cnt_next[INT_W-1:0];
        end
      end
    end
  end

  assign tick = tick_q;

  // R1: every tick is the result of a prescaled enable
  a_r1_tick_needs_en: assert property (@(posedge clk) disable iff (rst)
    tick_q |-> $past(en));

  // R7: a zero integer part keeps the tick low
  a_r7_zero_quiet: assert property (@(posedge clk) disable iff (rst)
    (n == '0) |=> !tick_q);

  // R2: the count never runs past the longest allowed period
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    ($stable(n) && n != '0) |-> (cnt_q <= n));
endmodule

// File: rtl/fbg_bitcnt.sv
module fbg_bitcnt #(
  parameter int OVS_HI = 16,
  parameter int OVS_LO = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic reload,
  input  logic mode_lo,
  input  logic samp,
  output logic bit_tick
);
  localparam int CW = $clog2(OVS_HI);
  localparam logic [CW-1:0] LAST_HI = CW'(OVS_HI - 1);
  localparam logic [CW-1:0] LAST_LO = CW'(OVS_LO - 1);

  logic [CW-1:0] cnt_q;
  logic          bit_q;
  logic [CW-1:0] last;

  assign last = mode_lo ? LAST_LO : LAST_HI;

  always_ff @(posedge clk) begin
    if (rst || reload) begin
      cnt_q <= '0;
      bit_q <= 1'b0;
    end else begin
      bit_q <= 1'b0;
      if (samp) begin
        if (cnt_q == last) begin
          cnt_q <= '0;
          bit_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign bit_tick = bit_q;

  // R5: a bit tick always follows a sample tick by one cycle
  a_r5_bit_after_samp: assert property (@(posedge clk) disable iff (rst)
    bit_q |-> $past(samp));

  // R6: the group count stays inside the selected group length
  a_r6_group_range: assert property (@(posedge clk) disable iff (rst)
    $stable(mode_lo) |-> (cnt_q <= last));
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int FRAC_W  = 4,
  parameter int PRE_DIV = 4,
  parameter int OVS_HI  = 16,
  parameter int OVS_LO  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        div_hi,
  input  logic [7:0]        div_lo,
  input  logic [FRAC_W-1:0] div_frac,
  input  logic              pre_sel,
  input  logic              mode_8x,
  output logic              samp_tick,
  output logic              bit_tick
);
  import fbg_pkg::*;

  fbg_cfg_t cfg_now;
  fbg_cfg_t cfg_q;
  logic     reload;
  logic     pre_en;
  logic     samp;

  always_comb begin
    cfg_now.int_part  = {div_hi, div_lo};
    cfg_now.frac_part = 4'(div_frac);
    cfg_now.pre_sel   = pre_sel;
    cfg_now.mode_8x   = mode_8x;
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg_now;
  end

  assign reload = (cfg_now != cfg_q);

  fbg_prescaler #(.RATIO(PRE_DIV)) u_pre (
    .clk(clk), .rst(rst), .reload(reload), .sel(pre_sel), .en(pre_en)
  );

  fbg_divider #(.INT_W(DIV_W), .FRAC_W(FRAC_W)) u_div (
    .clk(clk), .rst(rst), .reload(reload), .en(pre_en),
    .n(cfg_now.int_part), .f(div_frac), .tick(samp)
  );

  fbg_bitcnt #(.OVS_HI(OVS_HI), .OVS_LO(OVS_LO)) u_bit (
    .clk(clk), .rst(rst), .reload(reload), .mode_lo(mode_8x),
    .samp(samp), .bit_tick(bit_tick)
  );

  assign samp_tick = samp;

  // R8: a restart leaves both outputs low on the following cycle
  a_r8_reload_quiet: assert property (@(posedge clk) disable iff (rst)
    reload |=> (!samp_tick && !bit_tick));

  // R9: outputs are low in the cycle after reset is applied
  a_r9_reset_low: assert property (@(posedge clk)
    rst |=> (!samp_tick && !bit_tick));
endmodule

// File: tb/test_frac_baud_gen.sv
`timescale 1ns/1ps
module test_frac_baud_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] div_hi = '0;
  logic [7:0] div_lo = '0;
  logic [3:0] div_frac = '0;
  logic       pre_sel = 1'b0;
  logic       mode_8x = 1'b0;
  logic       samp_tick;
  logic       bit_tick;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int cyc0 = 0;
  int st [0:63];
  int bt [0:7];
  int nst = 0;
  int nbt = 0;
  bit done = 1'b0;

  frac_baud_gen i_frac_baud_gen (
    .clk(clk), .rst(rst), .div_hi(div_hi), .div_lo(div_lo),
    .div_frac(div_frac), .pre_sel(pre_sel), .mode_8x(mode_8x),
    .samp_tick(samp_tick), .bit_tick(bit_tick)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic program_cfg(input logic [7:0] hi, input logic [7:0] lo,
                             input logic [3:0] fr, input logic ps, input logic m8);
    @(negedge clk);
    div_hi = hi; div_lo = lo; div_frac = fr; pre_sel = ps; mode_8x = m8;
    cyc0 = cyc;
  endtask

  task automatic collect(input int ns, input int nb, input int lim);
    nst = 0; nbt = 0;
    for (int k = 0; k < lim && (nst < ns || nbt < nb); k++) begin
      @(negedge clk);
      if (samp_tick && nst < 64) begin st[nst] = cyc; nst++; end
      if (bit_tick && nbt < 8) begin bt[nbt] = cyc; nbt++; end
    end
  endtask

  task automatic window_check(input string req, input int first, input int n,
                              input int f, input int scale);
    int sum = 0;
    int bad = 0;
    for (int i = first; i < first + 16; i++) begin
      int d = st[i+1] - st[i];
      sum += d;
      if (d != n * scale && d != (n + 1) * scale) bad++;
    end
    chk({req, " intervals outside N..N+1"}, bad, 0);
    chk({req, " 16-interval sum"}, sum, (16 * n + f) * scale);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 samp_tick in reset", int'(samp_tick), 0);
    chk("R9 bit_tick in reset", int'(bit_tick), 0);
    rst = 1'b0;
    collect(1, 1, 50);
    chk("R9/R7 ticks after reset with zero divisor", nst + nbt, 0);
  endtask

  task automatic t_zero_int;
    program_cfg(8'h00, 8'h00, 4'h5, 1'b0, 1'b0);
    collect(1, 1, 80);
    chk("R7 zero integer part with fraction", nst + nbt, 0);
  endtask

  task automatic t_integer;
    program_cfg(8'h00, 8'h05, 4'h0, 1'b0, 1'b0);
    collect(6, 0, 100);
    chk("R8 first tick latency N+2", st[0] - cyc0, 7);
    for (int i = 0; i < 5; i++) chk("R1 integer interval", st[i+1] - st[i], 5);
  endtask

  task automatic t_collision;
    collect(1, 0, 20);
    repeat (3) @(negedge clk);
    program_cfg(8'h00, 8'h07, 4'h0, 1'b0, 1'b0);
    collect(1, 0, 40);
    chk("R8 pending tick dropped, restart latency", st[0] - cyc0, 9);
  endtask

  task automatic t_frac_312;
    program_cfg(8'h01, 8'h38, 4'h8, 1'b0, 1'b0);
    collect(18, 0, 7000);
    chk("R2 tick count", nst, 18);
    window_check("R2", 0, 312, 8, 1);
  endtask

  task automatic t_frac_small;
    program_cfg(8'h00, 8'h01, 4'hA, 1'b0, 1'b0);
    collect(40, 3, 200);
    window_check("R3 first window", 0, 1, 10, 1);
    window_check("R3 second window", 16, 1, 10, 1);
    chk("R5 bit tick one cycle after 16th sample", bt[0] - st[15], 1);
    chk("R5 16X bit period", bt[1] - bt[0], 26);
    chk("R5 16X second bit period", bt[2] - bt[1], 26);
  endtask

  task automatic t_acc_clear;
    program_cfg(8'h00, 8'h03, 4'hF, 1'b0, 1'b0);
    collect(5, 0, 60);
    program_cfg(8'h00, 8'h03, 4'hE, 1'b0, 1'b0);
    collect(3, 0, 60);
    chk("R8 latency after fraction change", st[0] - cyc0, 5);
    chk("R8 cleared accumulator, interval 1", st[1] - st[0], 3);
    chk("R8 cleared accumulator, interval 2", st[2] - st[1], 4);
  endtask

  task automatic t_prescale;
    program_cfg(8'h00, 8'h03, 4'h0, 1'b1, 1'b0);
    collect(5, 0, 200);
    for (int i = 0; i < 4; i++) chk("R4 prescaled interval", st[i+1] - st[i], 12);
  endtask

  task automatic t_mode8;
    program_cfg(8'h00, 8'h04, 4'h0, 1'b0, 1'b1);
    collect(0, 2, 200);
    chk("R6 8X bit period", bt[1] - bt[0], 32);
    program_cfg(8'h00, 8'h03, 4'h6, 1'b0, 1'b1);
    collect(0, 3, 300);
    chk("R6 8X fractional two-bit span", bt[2] - bt[0], 54);
  endtask

  task automatic t_3750;
    program_cfg(8'h0E, 8'hA6, 4'h0, 1'b0, 1'b0);
    collect(0, 2, 125000);
    chk("R10 bit ticks seen", nbt, 2);
    chk("R10 cycles per bit at divisor 3750", bt[1] - bt[0], 60000);
  endtask

  initial begin
    t_reset();
    t_zero_int();
    t_integer();
    t_collision();
    t_frac_312();
    t_frac_small();
    t_acc_clear();
    t_prescale();
    t_mode8();
    t_3750();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule